// File: doc/BRIEF.md
# Qualified Event Counter

This block is one programmable monitoring counter. It takes a vector of event condition lines. Each line has a fixed tag made of an 8-bit event code and one unit-mask bit position. Software programs a control word with a code, a mask, a threshold, an invert bit, an edge bit and an enable bit. In every cycle the block keeps the active lines whose code equals the programmed code and whose mask bit lies inside the programmed mask, and counts how many of them are active.

The qualifiers then set what is added to the counter in that cycle. With a zero threshold the counter adds the raw per-cycle count, which gives occupancy-style totals. With a nonzero threshold the counter adds one when the count meets the threshold. The invert bit turns that test into a below-threshold test. In edge mode the counter adds one only when the qualified condition turns from false to true.

Software reaches the block through a small port with two words. Address 0 is the control word and address 1 is the counter. Both words can be read back and written. There is no interrupt, no chaining into another counter and no privilege filtering.

Top module: `evq_counter`

## Requirements
- R1: After reset both the control word and the counter read as zero, so the counter starts disabled.
- R2: Line i carries code CODE_BASE + i / LINES_PER_CODE and mask bit i % LINES_PER_CODE. A line contributes only when it is active, its code equals the programmed code, and its mask bit is set in the programmed mask. Several mask bits OR their sub-events together.
- R3: When the threshold is zero and edge mode is off, each enabled cycle adds the number of contributing lines.
- R4: When the threshold is nonzero and invert is clear, each enabled cycle adds one if the contributing count is greater than or equal to the threshold, and adds nothing otherwise.
- R5: When the threshold is nonzero and invert is set, a cycle adds one only if the contributing count is below the threshold. When the threshold is zero, invert has no effect.
- R6: In edge mode the counter adds exactly one in a cycle where the qualified condition is true and was false in the previous cycle. With a zero threshold the qualified condition is "count nonzero".
- R7: The edge history is cleared by any control write and by the counter being disabled, so a condition that is still true afterwards is counted once more.
- R8: With the enable bit clear the counter holds its value.
- R9: Writing address 1 loads the counter. The load takes priority over an increment in the same cycle.
- R10: The counter is CNT_W bits wide and wraps silently from all ones to zero.
- R11: The control word is read and written at address 0 with this layout: code in bits 7:0, mask in 15:8, threshold in 23:16, invert in 24, edge in 25, enable in 26. Bits above 26 read as zero.
- R12: The counter does not advance in a cycle in which the control word is written.
- R13: An event-line change in one cycle is reflected in the counter read back after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Event condition lines |
| cfg_wr | input | 1 | Register write strobe |
| cfg_waddr | input | 1 | Write address: 0 control, 1 counter |
| cfg_wdata | input | CNT_W | Write data |
| cfg_raddr | input | 1 | Read address: 0 control, 1 counter |
| cfg_rdata | output | CNT_W | Read data, combinational |

## Verification
The bench builds the block with NUM_EVT = 8 and LINES_PER_CODE = 4, which gives two codes, 08h and 09h, with four mask bits each. Mask filtering, code mismatch and multi-bit masks can therefore all be seen on one input vector. It uses CNT_W = 32, which still holds the 27-bit control word and lets a wrap be reached within a few cycles after a counter load. TREE_SUM = 1 selects the adder-tree popcount, and thresholds of 2 and 3 fall inside the reachable per-cycle counts, so both sides of each comparison are exercised.

// File: rtl/evq_pkg.sv
package evq_pkg;

   // Control word; packed order places enable at bit 26 and code at 7:0
   typedef struct packed {
      logic       en;
      logic       edge_md;
      logic       inv;
      logic [7:0] thr;
      logic [7:0] umask;
      logic [7:0] code;
   } evq_ctl_t;

   localparam int CTL_W = $bits(evq_ctl_t);

endpackage

// File: rtl/evq_select.sv
module evq_select #(
   parameter int         NUM_EVT        = 8,
   parameter logic [7:0] CODE_BASE      = 8'h08,
   parameter int         LINES_PER_CODE = 4,
   parameter bit         TREE_SUM       = 1'b1,
   parameter int         SUM_W          = $clog2(NUM_EVT + 1)
) (
   input  logic [NUM_EVT-1:0] evt,
   input  logic [7:0]         code,
   input  logic [7:0]         umask,
   output logic [SUM_W-1:0]   sum
);

   logic [NUM_EVT-1:0] sel;

   // Per-line tag match: code equality and mask-bit membership
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_line
      localparam logic [7:0] LCODE = CODE_BASE + 8'(i / LINES_PER_CODE);
      localparam int         LBIT  = i % LINES_PER_CODE;
      assign sel[i] = evt[i] && (code == LCODE) && umask[LBIT];
   end

   if (TREE_SUM) begin : g_tree
      localparam int LV = $clog2(NUM_EVT);
      localparam int P2 = 1 << LV;
      logic [SUM_W-1:0] node [1:2*P2-1];
      for (genvar j = 0; j < P2; j++) begin : g_leaf
         if (j < NUM_EVT) begin : g_used
            assign node[P2+j] = SUM_W'(sel[j]);
         end else begin : g_pad
            assign node[P2+j] = '0;
         end
      end
      for (genvar k = 1; k < P2; k++) begin : g_node
         assign node[k] = node[2*k] + node[2*k+1];
      end
      assign sum = node[1];
   end else begin : g_chain
      always_comb begin
         sum = '0;
         for (int i = 0; i < NUM_EVT; i++) begin
            sum = sum + SUM_W'(sel[i]);
         end
      end
   end

endmodule

// File: rtl/evq_qualify.sv
module evq_qualify #(
   parameter int SUM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUM_W-1:0] sum,
   input  logic [7:0]       thr,
   input  logic             inv,
   input  logic             edge_md,
   input  logic             en,
   input  logic             clr_hist,
   output logic [SUM_W-1:0] inc
);

   logic thr_zero;
   logic cond;
   logic hist_q;

   assign thr_zero = (thr == 8'd0);

   always_comb begin
      if (thr_zero) begin
         cond = (sum != '0);
      end else if (inv) begin
         cond = (int'(sum) < int'(thr));
      end else begin
         cond = (int'(sum) >= int'(thr));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en || clr_hist) begin
         hist_q <= 1'b0;
      end else begin
         hist_q <= cond;
      end
   end

   always_comb begin
      if (!en) begin
         inc = '0;
      end else if (edge_md) begin
         inc = SUM_W'(cond && !hist_q);
      end else if (thr_zero) begin
         inc = sum;
      end else begin
         inc = SUM_W'(cond);
      end
   end

endmodule

// File: rtl/evq_accum.sv
module evq_accum #(
   parameter int CNT_W = 48,
   parameter int SUM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [SUM_W-1:0] inc,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else begin
         cnt <= cnt + CNT_W'(inc);
      end
   end

endmodule

// File: rtl/evq_counter.sv
module evq_counter #(
   parameter int         NUM_EVT        = 8,
   parameter int         CNT_W          = 48,
   parameter logic [7:0] CODE_BASE      = 8'h08,
   parameter int         LINES_PER_CODE = 4,
   parameter bit         TREE_SUM       = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               cfg_wr,
   input  logic               cfg_waddr,
   input  logic [CNT_W-1:0]   cfg_wdata,
   input  logic               cfg_raddr,
   output logic [CNT_W-1:0]   cfg_rdata
);
   import evq_pkg::*;

   localparam int SUM_W    = $clog2(NUM_EVT + 1);
   localparam int LAST_OFS = (NUM_EVT - 1) / LINES_PER_CODE;

   if (NUM_EVT < 1) begin : g_bad_num
      $error("NUM_EVT must be at least 1");
   end
   if (CNT_W < CTL_W) begin : g_bad_width
      $error("CNT_W must hold the control word");
   end
   if (LINES_PER_CODE < 1 || LINES_PER_CODE > 8) begin : g_bad_lpc
      $error("LINES_PER_CODE must be 1 to 8");
   end
   if (int'(CODE_BASE) + LAST_OFS > 255) begin : g_bad_code
      $error("line codes exceed 8 bits");
   end

   evq_ctl_t         ctl_q;
   logic             ctl_wr;
   logic             cnt_wr;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] inc;
   logic [SUM_W-1:0] inc_g;
   logic [CNT_W-1:0] cnt_q;

   assign ctl_wr = cfg_wr && !cfg_waddr;
   assign cnt_wr = cfg_wr && cfg_waddr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_wr) begin
         ctl_q <= evq_ctl_t'(cfg_wdata[CTL_W-1:0]);
      end
   end

   evq_select #(
      .NUM_EVT(NUM_EVT), .CODE_BASE(CODE_BASE),
      .LINES_PER_CODE(LINES_PER_CODE), .TREE_SUM(TREE_SUM), .SUM_W(SUM_W)
   ) u_sel (
      .evt(evt_i), .code(ctl_q.code), .umask(ctl_q.umask), .sum(sum)
   );

   evq_qualify #(.SUM_W(SUM_W)) u_qual (
      .clk(clk), .rst_n(rst_n), .sum(sum), .thr(ctl_q.thr), .inv(ctl_q.inv),
      .edge_md(ctl_q.edge_md), .en(ctl_q.en), .clr_hist(ctl_wr), .inc(inc)
   );

   // A control write cycle contributes nothing to the count
   assign inc_g = ctl_wr ? '0 : inc;

   evq_accum #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .load(cnt_wr), .load_val(cfg_wdata),
      .inc(inc_g), .cnt(cnt_q)
   );

   assign cfg_rdata = cfg_raddr ? cnt_q : CNT_W'(ctl_q);

endmodule

// File: rtl/evq_counter_chk.sv
module evq_counter_chk #(
   parameter int CNT_W   = 48,
   parameter int NUM_EVT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic             cfg_waddr,
   input logic [CNT_W-1:0] cfg_wdata,
   input logic             ctl_en,
   input logic             ctl_edge,
   input logic [7:0]       ctl_thr,
   input logic [CNT_W-1:0] cnt
);

   p_raw_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> (cnt - $past(cnt)) <= CNT_W'(NUM_EVT));

   p_thr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && ctl_thr != 8'd0 && !cfg_wr) |=> (cnt - $past(cnt)) <= CNT_W'(1));

   p_edge_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && ctl_edge && !cfg_wr) |=> (cnt - $past(cnt)) <= CNT_W'(1));

   p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_en && !cfg_wr) |=> cnt == $past(cnt));

   p_cnt_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_waddr) |=> cnt == $past(cfg_wdata));

   p_ctl_write_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_waddr) |=> cnt == $past(cnt));

endmodule

bind evq_counter evq_counter_chk #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
   .cfg_wdata(cfg_wdata), .ctl_en(ctl_q.en), .ctl_edge(ctl_q.edge_md),
   .ctl_thr(ctl_q.thr), .cnt(cnt_q)
);

// File: tb/sim_evq_counter.sv
module sim_evq_counter;

   localparam int W = 32;
   localparam int NV = 13;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   evt_i = '0;
   logic         cfg_wr = 1'b0;
   logic         cfg_waddr = 1'b0;
   logic [W-1:0] cfg_wdata = '0;
   logic         cfg_raddr = 1'b0;
   logic [W-1:0] cfg_rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   evq_counter #(.NUM_EVT(8), .CNT_W(W), .CODE_BASE(8'h08),
                 .LINES_PER_CODE(4), .TREE_SUM(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cfg_wr(cfg_wr),
      .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
      .cfg_rdata(cfg_rdata)
   );

   // {req[71:64], ctl[63:32], evt[31:24], cycles[23:16], expected[15:0]}
   // Lines 0-3: code 08h, mask bits 0-3; lines 4-7: code 09h, mask bits 0-3
   localparam logic [71:0] VEC [NV] = '{
      {8'd2, 32'h0400_0108, 8'h0F, 8'd3, 16'd3}, // R2 single mask bit
      {8'd2, 32'h0400_0308, 8'h0F, 8'd3, 16'd6}, // R2 mask 03h ORs two
      {8'd3, 32'h0400_0F08, 8'hFF, 8'd2, 16'd8}, // R3 raw sum, other code out
      {8'd2, 32'h0400_0C09, 8'hFF, 8'd2, 16'd4}, // R2 second code
      {8'd4, 32'h0403_0F08, 8'h07, 8'd4, 16'd4}, // R4 count equals thr
      {8'd4, 32'h0403_0F08, 8'h03, 8'd4, 16'd0}, // R4 count below thr
      {8'd5, 32'h0503_0F08, 8'h03, 8'd4, 16'd4}, // R5 inverted, below
      {8'd5, 32'h0503_0F08, 8'h07, 8'd4, 16'd0}, // R5 inverted, equal
      {8'd5, 32'h0500_0F08, 8'h03, 8'd3, 16'd6}, // R5 invert ignored at thr 0
      {8'd6, 32'h0600_0F08, 8'h0F, 8'd5, 16'd1}, // R6 edge, raw condition
      {8'd6, 32'h0602_0F08, 8'h03, 8'd5, 16'd1}, // R6 edge with thr
      {8'd8, 32'h0000_0F08, 8'h0F, 8'd4, 16'd0}, // R8 disabled
      {8'd6, 32'h0702_0F08, 8'h0F, 8'd3, 16'd0}  // R6 edge, inverted false
   };

   task automatic chk(input int req, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL R%0d got %h exp %h", req, got, exp);
      end
   endtask

   // Entered and left on a falling edge; one rising edge performs the write
   task automatic wr(input logic a, input logic [W-1:0] d);
      cfg_wr = 1'b1;
      cfg_waddr = a;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input int req, input logic a, input logic [W-1:0] exp);
      cfg_raddr = a;
      #1;
      chk(req, cfg_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(1, 1'b0, '0);
      rd(1, 1'b1, '0);

      // R11 control readback, bits above 26 dropped
      wr(1'b0, 32'hFFFF_FFFF);
      rd(11, 1'b0, 32'h07FF_FFFF);

      for (int v = 0; v < NV; v++) begin
         evt_i = '0;
         wr(1'b0, VEC[v][63:32]);
         wr(1'b1, '0);
         evt_i = VEC[v][31:24];
         repeat (int'(VEC[v][23:16])) @(negedge clk);
         evt_i = '0;
         rd(int'(VEC[v][71:64]), 1'b1, W'(VEC[v][15:0]));
      end

      // R9 load wins over increment; R13 one-edge latency
      wr(1'b0, 32'h0400_0108);
      evt_i = 8'h01;
      wr(1'b1, 32'd100);
      rd(9, 1'b1, 32'd100);
      @(negedge clk);
      rd(13, 1'b1, 32'd101);

      // R10 wrap
      wr(1'b1, 32'hFFFF_FFFE);
      repeat (3) @(negedge clk);
      rd(10, 1'b1, 32'd1);

      // R12 control write cycle holds the count
      wr(1'b1, '0);
      repeat (2) @(negedge clk);
      rd(3, 1'b1, 32'd2);
      wr(1'b0, 32'h0400_0108);
      rd(12, 1'b1, 32'd2);
      repeat (2) @(negedge clk);
      rd(12, 1'b1, 32'd4);

      // R7 edge history cleared by reprogramming and by disable
      evt_i = '0;
      wr(1'b0, 32'h0600_0F08);
      wr(1'b1, '0);
      evt_i = 8'h01;
      repeat (3) @(negedge clk);
      rd(6, 1'b1, 32'd1);
      wr(1'b0, 32'h0600_0F08);
      repeat (3) @(negedge clk);
      rd(7, 1'b1, 32'd2);
      wr(1'b0, 32'h0200_0F08);
      repeat (2) @(negedge clk);
      rd(8, 1'b1, 32'd2);
      wr(1'b0, 32'h0600_0F08);
      repeat (2) @(negedge clk);
      rd(7, 1'b1, 32'd3);
      evt_i = '0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule